// File: doc/BRIEF.md
# Two-Stage Escalating Watchdog Timer

This block supervises software with a timer that escalates in two steps. Software arms it through a small register port on a host I/O bus: one control register holds an enable bit, an interrupt-enable bit, a lock bit and a 3-bit duration select. Every write to that register also services (refreshes) the timer. A prescaler divides the system clock into a base tick. The first stage counts down the selected number of ticks. When it runs out, the block raises a one-tick interrupt request, if interrupts are enabled. A fixed second stage of eight ticks follows. If software still has not serviced the timer at the end of that stage, the block emits a system reset pulse.

The eight first-stage durations grow by factors of four, from 16 ticks up to 262144 ticks. When the lock bit is set, the enable bit cannot be changed. The watchdog therefore cannot be switched off or on until the lock is released. After the block fires a reset it returns to the disabled state, as it does after its own reset input.

Top module: `wdt2_top`

## Requirements
- R1: After reset the control register reads 0x00, both outputs are low, and nothing fires while the enable bit is 0. Only a control-register write can set the enable bit.
- R2: The control register sits at address 0 with enable in bit 0, interrupt enable in bit 1, lock in bit 2 and duration select in bits 6:4. Bits 7 and 3 read as 0. A read returns the value one clock after the read strobe. Writes to any other address change nothing and do not refresh the timer.
- R3: A tick lasts PRESCALE clocks. With select s, the first stage lasts 16·4^s ticks, measured from the clock edge that captures the enabling write.
- R4: At the end of the first stage `nmi_o` goes high for exactly one tick, but only if the interrupt-enable bit is 1. If that bit is 0, no pulse is produced.
- R5: Eight ticks after the end of the first stage, `wd_rst_o` goes high for RST_PULSE clocks. The enable bit then reads 0.
- R6: Any write to the control register while the timer runs in the first stage restarts the full first-stage count.
- R7: A write to the control register during the second stage cancels the pending reset and restarts the first stage at its full length.
- R8: While the lock bit is 1, a control-register write leaves the enable bit unchanged. The other fields still update, and the write still refreshes the timer.
- R9: A new duration select takes effect from the control write that carries it. The time spent on the old duration does not count toward the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one clock per access |
| bus_rd | input | 1 | Read strobe, one clock per access |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| nmi_o | output | 1 | Interrupt request, one tick wide |
| wd_rst_o | output | 1 | System reset request pulse |

## Verification
The timer is run in several ways and left to expire: with the interrupt enabled, with it disabled, and with two different duration selects. These runs separate the correct preset and tick scaling from an off-by-one error or a wrong power of four. Refreshes are placed in the middle of the first stage and just after the interrupt. These show whether the reload is complete, and whether the pending reset is truly cancelled rather than only delayed. A write to a non-control address during a run checks that stray bus traffic does not service the timer. Lock sequences that try to switch the timer off, and then on, while locked check that the enable bit stays frozen in both directions while the other fields still change.

// File: rtl/wdt2_pkg.sv
package wdt2_pkg;
  localparam int SEL_W     = 3;
  localparam int BASE_LOG2 = 4;
  localparam int STEP_LOG2 = 2;
  localparam int CNT_W     = BASE_LOG2 + STEP_LOG2 * ((1 << SEL_W) - 1) + 1;

  typedef enum logic [1:0] {ST_IDLE, ST_S1, ST_S2} wd_stage_e;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic             lock;
    logic             nmi_en;
    logic             en;
  } wd_ctrl_t;

  function automatic logic [CNT_W-1:0] preset_ticks(input logic [SEL_W-1:0] s);
    return CNT_W'(1) << (BASE_LOG2 + STEP_LOG2 * int'(s));
  endfunction
endpackage

// File: rtl/wdt2_prescaler.sv
module wdt2_prescaler #(
  parameter int PRESCALE = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic clear,
  output logic tick
);
  generate
    if (PRESCALE <= 1) begin : g_direct
      assign tick = run && !clear;
    end else begin : g_count
      localparam int PW = $clog2(PRESCALE);
      logic [PW-1:0] pcnt;
      always_ff @(posedge clk) begin
        if (rst || clear || !run) pcnt <= '0;
        else if (pcnt == PW'(PRESCALE - 1)) pcnt <= '0;
        else pcnt <= pcnt + 1'b1;
      end
      assign tick = run && !clear && (pcnt == PW'(PRESCALE - 1));

      AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick); // R3
    end
  endgenerate
endmodule

// File: rtl/wdt2_regs.sv
module wdt2_regs
  import wdt2_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              fire_i,
  output logic              reload_o,
  output wd_ctrl_t          ctrl_nxt_o,
  output wd_ctrl_t          ctrl_o,
  output logic [7:0]        bus_rdata
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = '0;

  wd_ctrl_t ctrl_q;
  wd_ctrl_t ctrl_d;
  logic     wr_ctrl;

  assign wr_ctrl = bus_wr && (bus_addr == CTRL_ADDR);

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) begin
      ctrl_d.sel    = bus_wdata[6:4];
      ctrl_d.lock   = bus_wdata[2];
      ctrl_d.nmi_en = bus_wdata[1];
      if (!ctrl_q.lock) ctrl_d.en = bus_wdata[0];
    end
    if (fire_i) ctrl_d.en = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      bus_rdata <= '0;
    end else begin
      ctrl_q    <= ctrl_d;
      bus_rdata <= (bus_rd && bus_addr == CTRL_ADDR)
                   ? {1'b0, ctrl_q.sel, 1'b0, ctrl_q.lock, ctrl_q.nmi_en, ctrl_q.en}
                   : 8'h00;
    end
  end

  assign reload_o   = wr_ctrl;
  assign ctrl_nxt_o = ctrl_d;
  assign ctrl_o     = ctrl_q;

  AST_ENABLE_BY_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!$past(ctrl_q.en) && ctrl_q.en) |-> $past(wr_ctrl)); // R1
  AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (rst)
    ($past(ctrl_q.lock) && !$past(fire_i)) |-> (ctrl_q.en == $past(ctrl_q.en))); // R8
endmodule

// File: rtl/wdt2_core.sv
module wdt2_core
  import wdt2_pkg::*;
#(
  parameter int STAGE2_TICKS = 8,
  parameter int RST_PULSE    = 4
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     tick,
  input  logic     reload,
  input  wd_ctrl_t ctrl_nxt,
  input  wd_ctrl_t ctrl,
  output logic     fire_o,
  output logic     nmi_o,
  output logic     wd_rst_o
);
  localparam int RW = $clog2(RST_PULSE + 1);

  wd_stage_e        stage_q;
  logic [CNT_W-1:0] cnt_q;
  logic             nmi_q;
  logic [RW-1:0]    rcnt_q;
  logic             last_tick;

  assign last_tick = tick && (cnt_q == CNT_W'(1));
  assign fire_o    = !reload && ctrl.en && last_tick && (stage_q == ST_S2);

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= ST_IDLE;
      cnt_q   <= '0;
      nmi_q   <= 1'b0;
      rcnt_q  <= '0;
    end else begin
      if (rcnt_q != '0) rcnt_q <= rcnt_q - 1'b1;
      if (reload) begin
        nmi_q   <= 1'b0;
        stage_q <= ctrl_nxt.en ? ST_S1 : ST_IDLE;
        cnt_q   <= ctrl_nxt.en ? preset_ticks(ctrl_nxt.sel) : '0;
      end else if (!ctrl.en) begin
        stage_q <= ST_IDLE;
        nmi_q   <= 1'b0;
      end else if (tick) begin
        nmi_q <= 1'b0;
        unique case (stage_q)
          ST_S1: begin
            if (last_tick) begin
              stage_q <= ST_S2;
              cnt_q   <= CNT_W'(STAGE2_TICKS);
              nmi_q   <= ctrl.nmi_en;
            end else begin
              cnt_q <= cnt_q - 1'b1;
            end
          end
          ST_S2: begin
            if (last_tick) begin
              stage_q <= ST_IDLE;
              rcnt_q  <= RW'(RST_PULSE);
            end else begin
              cnt_q <= cnt_q - 1'b1;
            end
          end
          default: stage_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign nmi_o    = nmi_q;
  assign wd_rst_o = (rcnt_q != '0);

  AST_NMI_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    $rose(nmi_q) |-> ctrl.nmi_en); // R4
  AST_RST_FROM_STAGE2: assert property (@(posedge clk) disable iff (rst)
    $rose(wd_rst_o) |-> ($past(stage_q) == ST_S2)); // R5
  AST_RST_DISABLES: assert property (@(posedge clk) disable iff (rst)
    $rose(wd_rst_o) |-> !ctrl.en); // R5
  AST_NMI_NOT_WITH_RST: assert property (@(posedge clk) disable iff (rst)
    !(nmi_q && wd_rst_o)); // R4
endmodule

// File: rtl/wdt2_top.sv
module wdt2_top
  import wdt2_pkg::*;
#(
  parameter int ADDR_W       = 2,
  parameter int PRESCALE     = 4,
  parameter int STAGE2_TICKS = 8,
  parameter int RST_PULSE    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              nmi_o,
  output logic              wd_rst_o
);
  wd_ctrl_t ctrl_q;
  wd_ctrl_t ctrl_nxt;
  logic     reload;
  logic     fire;
  logic     tick;

  wdt2_regs #(.ADDR_W(ADDR_W)) i_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .fire_i(fire),
    .reload_o(reload), .ctrl_nxt_o(ctrl_nxt), .ctrl_o(ctrl_q),
    .bus_rdata(bus_rdata)
  );

  wdt2_prescaler #(.PRESCALE(PRESCALE)) i_presc (
    .clk(clk), .rst(rst), .run(ctrl_q.en), .clear(reload), .tick(tick)
  );

  wdt2_core #(.STAGE2_TICKS(STAGE2_TICKS), .RST_PULSE(RST_PULSE)) i_core (
    .clk(clk), .rst(rst), .tick(tick), .reload(reload),
    .ctrl_nxt(ctrl_nxt), .ctrl(ctrl_q), .fire_o(fire),
    .nmi_o(nmi_o), .wd_rst_o(wd_rst_o)
  );
endmodule

// File: tb/test_wdt2_top.sv
module test_wdt2_top;
  localparam int CLK_PERIOD = 10;
  localparam int P          = 4;
  localparam int RSTW       = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       nmi_o;
  logic       wd_rst_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int last_c0 = 0;
  int exp_kind[$];
  int exp_cyc[$];
  int seen_events = 0;
  logic en_m = 0, lock_m = 0, nen_m = 0;
  logic [2:0] sel_m = 0;

  wdt2_top #(.ADDR_W(2), .PRESCALE(P), .STAGE2_TICKS(8), .RST_PULSE(RSTW)) i_wdt2_top (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .nmi_o(nmi_o), .wd_rst_o(wd_rst_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard when an output pulse starts
  int nmi_w = 0, rst_w = 0;
  logic nmi_p = 0, rst_p = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (nmi_o && !nmi_p) begin
        seen_events++;
        if (exp_kind.size() == 0) check(0, "R4 unexpected nmi", cyc, -1);
        else begin
          check(exp_kind[0] == 0, "R4 event kind", 0, exp_kind[0]);
          check(exp_cyc[0] == cyc, "R3 nmi cycle", cyc, exp_cyc[0]);
          void'(exp_kind.pop_front()); void'(exp_cyc.pop_front());
        end
      end
      if (rst_p && !wd_rst_o) check(rst_w == RSTW, "R5 reset width", rst_w, RSTW);
      if (nmi_p && !nmi_o)    check(nmi_w == P, "R4 nmi width", nmi_w, P);
      if (wd_rst_o && !rst_p) begin
        seen_events++;
        en_m = 0;
        if (exp_kind.size() == 0) check(0, "R5 unexpected reset", cyc, -1);
        else begin
          check(exp_kind[0] == 1, "R5 event kind", 1, exp_kind[0]);
          check(exp_cyc[0] == cyc, "R5 reset cycle", cyc, exp_cyc[0]);
          void'(exp_kind.pop_front()); void'(exp_cyc.pop_front());
        end
      end
      nmi_w = nmi_o ? ((nmi_p ? nmi_w : 0) + 1) : nmi_w;
      rst_w = wd_rst_o ? ((rst_p ? rst_w : 0) + 1) : rst_w;
      nmi_p = nmi_o;
      rst_p = wd_rst_o;
    end
  end

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
    last_c0 = cyc;
  endtask

  // driver: control write plus scoreboard update
  task automatic wr_ctrl(input logic [7:0] d);
    int n;
    bus_write(2'd0, d);
    if (!lock_m) en_m = d[0];
    lock_m = d[2]; nen_m = d[1]; sel_m = d[6:4];
    exp_kind.delete(); exp_cyc.delete();
    if (en_m) begin
      n = 16 << (2 * int'(sel_m));
      if (nen_m) begin exp_kind.push_back(0); exp_cyc.push_back(last_c0 + n * P); end
      exp_kind.push_back(1); exp_cyc.push_back(last_c0 + (n + 8) * P);
    end
  endtask

  task automatic rd_chk(input string req);
    logic [7:0] e;
    e = {1'b0, sel_m, 1'b0, lock_m, nen_m, en_m};
    @(negedge clk); bus_rd = 1; bus_addr = 0;
    @(negedge clk); bus_rd = 0;
    check(bus_rdata == e, req, bus_rdata, e);
  endtask

  task automatic drain(input int clocks, input string req);
    repeat (clocks) @(negedge clk);
    check(exp_kind.size() == 0, req, exp_kind.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int ev0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    check(nmi_o == 0 && wd_rst_o == 0, "R1 outputs idle", nmi_o, 0);
    rd_chk("R1 reset readback");
    ev0 = seen_events;
    wr_ctrl(8'h02);                 // enable=0
    repeat (200) @(negedge clk);
    check(seen_events == ev0, "R1 disabled silent", seen_events, ev0);
    // R2 R3 R4 R5 full expiry sel0 with NMI
    wr_ctrl(8'h03);
    rd_chk("R2 readback enabled");
    drain(30 * P, "R5 events done");
    rd_chk("R5 enable cleared after fire");
    // R4 no NMI when interrupt disabled
    ev0 = seen_events;
    wr_ctrl(8'h01);
    drain(30 * P, "R4 reset only");
    check(seen_events == ev0 + 1, "R4 single event", seen_events, ev0 + 1);
    // R6 refresh mid first stage, sel1
    wr_ctrl(8'h13);
    repeat (40 * P) @(negedge clk);
    wr_ctrl(8'h13);
    drain(80 * P, "R6 reload full");
    // R7 refresh in second stage
    wr_ctrl(8'h03);
    repeat (18 * P) @(negedge clk);
    check(exp_kind.size() == 1, "R7 nmi already seen", exp_kind.size(), 1);
    wr_ctrl(8'h03);
    drain(30 * P, "R7 restart after cancel");
    // R2 stray write ignored while running
    wr_ctrl(8'h03);
    repeat (5 * P) @(negedge clk);
    bus_write(2'd1, 8'h00);
    bus_write(2'd3, 8'h70);
    rd_chk("R2 other address ignored");
    drain(30 * P, "R2 no refresh from stray write");
    // R9 duration change from sel1 to sel0 takes effect at its write
    wr_ctrl(8'h11);
    repeat (20 * P) @(negedge clk);
    wr_ctrl(8'h01);
    drain(30 * P, "R9 new duration");
    // R8 lock with enable on: disabling is refused, write still refreshes
    wr_ctrl(8'h05);
    repeat (10 * P) @(negedge clk);
    wr_ctrl(8'h04);
    rd_chk("R8 enable held on");
    repeat (10 * P) @(negedge clk);
    wr_ctrl(8'h00);                 // unlock, enable stays
    wr_ctrl(8'h00);                 // now disable
    rd_chk("R8 unlocked disable");
    // R8 lock with enable off: enabling is refused
    wr_ctrl(8'h04);
    wr_ctrl(8'h05);
    rd_chk("R8 enable held off");
    ev0 = seen_events;
    repeat (40 * P) @(negedge clk);
    check(seen_events == ev0, "R8 locked off silent", seen_events, ev0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule